// File: doc/BRIEF.md
# Protection Unit Fault Capture

This block sits beside a memory protection unit and turns the unit's access decisions into interrupts and fault records. The region-rule matcher is outside it and reports a broken rule on a bus transfer through a one-cycle violation strobe. That strobe comes with the transfer's address, its direction and the initiator identifier. The unit's own configuration port reports each access to its register space through a second strobe. That strobe carries a flag saying whether the address decoded to a real register, and a flag saying whether the access was permitted.

There are two interrupt sources. An access to an undecoded configuration address is an addressing fault. A rule break on the protected bus is a protection fault, and so is a refused access to the configuration registers. The first fault's parameters are latched and held until software writes the clear register. Later faults still raise their pending bits. A small word-indexed register bus gives access to the enable bits, to the raw pending bits (which software can also set), to the masked pending bits (write one to clear) and to the held fault record.

Word map on `reg_addr`: 0 enable, 1 raw status, 2 enabled status, 3 fault address, 4 fault status, 5 fault clear. All other indices read zero. Interrupt bit 0 is the addressing fault and bit 1 is the protection fault.

Top module: `pu_fault_capture`

## Requirements
- R1: A cycle with `cfg_acc` high and `cfg_hit` low sets raw bit 0 at the next clock edge.
- R2: A cycle with `xfer_viol` high sets raw bit 1 at the next clock edge.
- R3: A cycle with `cfg_acc` and `cfg_hit` high and `cfg_allow` low sets raw bit 1. A permitted, decoded configuration access changes no register.
- R4: When no fault is held, a fault event loads the fault address (word 3, zero-extended) and the fault status (word 4). The status holds bit 0 valid, bit 1 write, bit 2 kind (1 for an addressing fault) and the initiator ID from bit 3 upward.
- R5: While a fault is held, further fault events set raw bits but leave words 3 and 4 unchanged.
- R6: Any write to word 5 clears words 3 and 4 to zero, so the next fault is captured.
- R7: Each interrupt output is high exactly while its raw bit and its enable bit (word 0) are both set. It changes one clock edge after the write or event that causes the change.
- R8: A read of word 1 returns the raw pending bits. A read of word 2 returns the raw bits ANDed with the enable bits.
- R9: Writing word 2 clears each raw bit written as 1. Bits written as 0 are unaffected.
- R10: Writing word 1 sets each raw bit written as 1. Bits written as 0 are unaffected.
- R11: A hardware fault event wins over a same-cycle clear of its bit. When a transfer violation and a configuration fault arrive together, the transfer is the one captured.
- R12: After reset all words read zero, unmapped indices always read zero, and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_viol | input | 1 | Protected-bus transfer broke a rule (one-cycle strobe) |
| xfer_addr | input | ADDR_W | Address of that transfer |
| xfer_wr | input | 1 | 1 for a write transfer |
| xfer_id | input | ID_W | Initiator ID of that transfer |
| cfg_acc | input | 1 | Configuration-space access strobe |
| cfg_hit | input | 1 | Configuration address decoded to a register |
| cfg_allow | input | 1 | Configuration access permitted |
| cfg_addr | input | ADDR_W | Configuration access address |
| cfg_wr | input | 1 | 1 for a configuration write |
| cfg_id | input | ID_W | Configuration access initiator ID |
| reg_we | input | 1 | Register-bus write strobe |
| reg_addr | input | REG_AW | Register word index |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational from reg_addr) |
| irq_addr_err | output | 1 | Addressing-fault interrupt, level |
| irq_prot_err | output | 1 | Protection-fault interrupt, level |

## Verification
A pending bit that is wrong shows up on the interrupt line and in the raw-status read one edge after the event or write that should have set or cleared it. The bench reads both words after every such stimulus. A capture latch that reloads while a fault is held, or that does not reload after a clear, shows at once as a changed fault address or fault status on the next read. The bench therefore sweeps every initiator ID and direction, and every enable and pending combination, reading back after each step.

// File: rtl/pu_fault_pkg.sv
package pu_fault_pkg;
   // register word indices
   localparam int unsigned IDX_ENABLE = 0;
   localparam int unsigned IDX_RAW    = 1;
   localparam int unsigned IDX_ENSTAT = 2;
   localparam int unsigned IDX_FADDR  = 3;
   localparam int unsigned IDX_FSTAT  = 4;
   localparam int unsigned IDX_FCLR   = 5;
   // interrupt bits
   localparam int unsigned IRQ_N      = 2;
   localparam int unsigned BIT_ADDR   = 0;
   localparam int unsigned BIT_PROT   = 1;
   // fault status layout
   localparam int unsigned FS_VALID   = 0;
   localparam int unsigned FS_WR      = 1;
   localparam int unsigned FS_KIND    = 2;
   localparam int unsigned FS_ID_LSB  = 3;
endpackage

// File: rtl/pu_irq_bank.sv
module pu_irq_bank #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] hw_set,
   input  logic [N-1:0] sw_set,
   input  logic [N-1:0] sw_clr,
   input  logic         en_we,
   input  logic [N-1:0] en_wdata,
   output logic [N-1:0] raw_q,
   output logic [N-1:0] en_q,
   output logic [N-1:0] irq
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     raw_q[i] <= 1'b0;
            else if (hw_set[i] || sw_set[i]) raw_q[i] <= 1'b1;
            else if (sw_clr[i])             raw_q[i] <= 1'b0;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     en_q[i] <= 1'b0;
            else if (en_we) en_q[i] <= en_wdata[i];
         end
         assign irq[i] = raw_q[i] & en_q[i];
      end
   endgenerate
endmodule

// File: rtl/pu_fault_latch.sv
module pu_fault_latch #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned ID_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              ev_a,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic              a_wr,
   input  logic [ID_W-1:0]   a_id,
   input  logic              ev_b,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic              b_wr,
   input  logic [ID_W-1:0]   b_id,
   input  logic              b_kind,
   output logic              valid_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic              wr_q,
   output logic              kind_q,
   output logic [ID_W-1:0]   id_q
);
   logic take;
   assign take = (ev_a || ev_b) && (!valid_q || clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         addr_q  <= '0;
         wr_q    <= 1'b0;
         kind_q  <= 1'b0;
         id_q    <= '0;
      end else if (take) begin
         valid_q <= 1'b1;
         if (ev_a) begin
            addr_q <= a_addr;
            wr_q   <= a_wr;
            kind_q <= 1'b0;
            id_q   <= a_id;
         end else begin
            addr_q <= b_addr;
            wr_q   <= b_wr;
            kind_q <= b_kind;
            id_q   <= b_id;
         end
      end else if (clr) begin
         valid_q <= 1'b0;
         addr_q  <= '0;
         wr_q    <= 1'b0;
         kind_q  <= 1'b0;
         id_q    <= '0;
      end
   end
endmodule

// File: rtl/pu_fault_capture.sv
module pu_fault_capture
   import pu_fault_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned ID_W   = 4,
   parameter int unsigned REG_AW = 4,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_viol,
   input  logic [ADDR_W-1:0] xfer_addr,
   input  logic              xfer_wr,
   input  logic [ID_W-1:0]   xfer_id,
   input  logic              cfg_acc,
   input  logic              cfg_hit,
   input  logic              cfg_allow,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              cfg_wr,
   input  logic [ID_W-1:0]   cfg_id,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_addr_err,
   output logic              irq_prot_err
);
   localparam int unsigned FS_W = FS_ID_LSB + ID_W;

   generate
      if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr_w
         $error("ADDR_W must lie in 1..DATA_W");
      end
      if (ID_W < 1 || FS_W > DATA_W) begin : g_bad_id_w
         $error("fault status does not fit in DATA_W");
      end
      if ((1 << REG_AW) <= IDX_FCLR) begin : g_bad_reg_aw
         $error("REG_AW too narrow for the register map");
      end
   endgenerate

   logic cfg_addr_err, cfg_prot_err;
   assign cfg_addr_err = cfg_acc && !cfg_hit;
   assign cfg_prot_err = cfg_acc && cfg_hit && !cfg_allow;

   logic sel_en, sel_raw, sel_enstat, sel_fclr;
   assign sel_en     = reg_we && (reg_addr == REG_AW'(IDX_ENABLE));
   assign sel_raw    = reg_we && (reg_addr == REG_AW'(IDX_RAW));
   assign sel_enstat = reg_we && (reg_addr == REG_AW'(IDX_ENSTAT));
   assign sel_fclr   = reg_we && (reg_addr == REG_AW'(IDX_FCLR));

   logic [IRQ_N-1:0] hw_set, sw_set, sw_clr, raw_q, en_q, irq;
   assign hw_set[BIT_ADDR] = cfg_addr_err;
   assign hw_set[BIT_PROT] = xfer_viol || cfg_prot_err;
   assign sw_set = sel_raw    ? reg_wdata[IRQ_N-1:0] : '0;
   assign sw_clr = sel_enstat ? reg_wdata[IRQ_N-1:0] : '0;

   pu_irq_bank #(.N(IRQ_N)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_set   (hw_set),
      .sw_set   (sw_set),
      .sw_clr   (sw_clr),
      .en_we    (sel_en),
      .en_wdata (reg_wdata[IRQ_N-1:0]),
      .raw_q    (raw_q),
      .en_q     (en_q),
      .irq      (irq)
   );

   assign irq_addr_err = irq[BIT_ADDR];
   assign irq_prot_err = irq[BIT_PROT];

   logic              f_valid, f_wr, f_kind;
   logic [ADDR_W-1:0] f_addr;
   logic [ID_W-1:0]   f_id;

   pu_fault_latch #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (sel_fclr),
      .ev_a    (xfer_viol),
      .a_addr  (xfer_addr),
      .a_wr    (xfer_wr),
      .a_id    (xfer_id),
      .ev_b    (cfg_addr_err || cfg_prot_err),
      .b_addr  (cfg_addr),
      .b_wr    (cfg_wr),
      .b_id    (cfg_id),
      .b_kind  (cfg_addr_err),
      .valid_q (f_valid),
      .addr_q  (f_addr),
      .wr_q    (f_wr),
      .kind_q  (f_kind),
      .id_q    (f_id)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         REG_AW'(IDX_ENABLE): reg_rdata[IRQ_N-1:0] = en_q;
         REG_AW'(IDX_RAW):    reg_rdata[IRQ_N-1:0] = raw_q;
         REG_AW'(IDX_ENSTAT): reg_rdata[IRQ_N-1:0] = raw_q & en_q;
         REG_AW'(IDX_FADDR):  reg_rdata[ADDR_W-1:0] = f_addr;
         REG_AW'(IDX_FSTAT): begin
            reg_rdata[FS_VALID]           = f_valid;
            reg_rdata[FS_WR]              = f_wr;
            reg_rdata[FS_KIND]            = f_kind;
            reg_rdata[FS_ID_LSB +: ID_W]  = f_id;
         end
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/pu_fault_capture_chk.sv
module pu_fault_capture_chk
   import pu_fault_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned REG_AW = 4,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              xfer_viol,
   input logic              cfg_acc,
   input logic              cfg_hit,
   input logic              cfg_allow,
   input logic              reg_we,
   input logic [REG_AW-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [IRQ_N-1:0]  raw_q,
   input logic              fault_valid,
   input logic [ADDR_W-1:0] fault_addr
);
   logic wr_fclr, wr_enstat, any_cfg_fault;
   assign wr_fclr       = reg_we && (reg_addr == REG_AW'(IDX_FCLR));
   assign wr_enstat     = reg_we && (reg_addr == REG_AW'(IDX_ENSTAT));
   assign any_cfg_fault = cfg_acc && !(cfg_hit && cfg_allow);

   // R1
   addr_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_acc && !cfg_hit) |=> raw_q[BIT_ADDR]);
   // R2
   xfer_prot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_viol |=> raw_q[BIT_PROT]);
   // R3
   cfg_prot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_acc && cfg_hit && !cfg_allow) |=> raw_q[BIT_PROT]);
   // R5
   fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_valid && !wr_fclr) |=> (fault_valid && $stable(fault_addr)));
   // R6
   fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fclr && !xfer_viol && !any_cfg_fault) |=> !fault_valid);
   // R9
   w1c_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_enstat && reg_wdata[BIT_ADDR] && !(cfg_acc && !cfg_hit)) |=> !raw_q[BIT_ADDR]);
endmodule

bind pu_fault_capture pu_fault_capture_chk #(
   .ADDR_W (ADDR_W),
   .REG_AW (REG_AW),
   .DATA_W (DATA_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .xfer_viol   (xfer_viol),
   .cfg_acc     (cfg_acc),
   .cfg_hit     (cfg_hit),
   .cfg_allow   (cfg_allow),
   .reg_we      (reg_we),
   .reg_addr    (reg_addr),
   .reg_wdata   (reg_wdata),
   .raw_q       (raw_q),
   .fault_valid (f_valid),
   .fault_addr  (f_addr)
);

// File: tb/pu_fault_capture_bench.sv
module pu_fault_capture_bench;
   localparam int unsigned ADDR_W = 16;
   localparam int unsigned ID_W   = 3;
   localparam int unsigned REG_AW = 3;
   localparam int unsigned DATA_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              xfer_viol = 1'b0, xfer_wr = 1'b0;
   logic [ADDR_W-1:0] xfer_addr = '0;
   logic [ID_W-1:0]   xfer_id = '0;
   logic              cfg_acc = 1'b0, cfg_hit = 1'b0, cfg_allow = 1'b0, cfg_wr = 1'b0;
   logic [ADDR_W-1:0] cfg_addr = '0;
   logic [ID_W-1:0]   cfg_id = '0;
   logic              reg_we = 1'b0;
   logic [REG_AW-1:0] reg_addr = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic              irq_addr_err, irq_prot_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pu_fault_capture #(.ADDR_W(ADDR_W), .ID_W(ID_W), .REG_AW(REG_AW), .DATA_W(DATA_W))
   u_pu_fault_capture (
      .clk(clk), .rst_n(rst_n),
      .xfer_viol(xfer_viol), .xfer_addr(xfer_addr), .xfer_wr(xfer_wr), .xfer_id(xfer_id),
      .cfg_acc(cfg_acc), .cfg_hit(cfg_hit), .cfg_allow(cfg_allow),
      .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_id(cfg_id),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_addr_err(irq_addr_err), .irq_prot_err(irq_prot_err)
   );

   task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rd(input int idx, output logic [DATA_W-1:0] v);
      reg_addr = REG_AW'(idx);
      #0.5;
      v = reg_rdata;
   endtask

   task automatic check_rd(input string tag, input int idx, input logic [DATA_W-1:0] exp);
      logic [DATA_W-1:0] v;
      rd(idx, v);
      check(tag, v, exp);
   endtask

   task automatic wr(input int idx, input logic [DATA_W-1:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = REG_AW'(idx); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic xfer(input logic [ADDR_W-1:0] a, input logic w, input logic [ID_W-1:0] id);
      @(negedge clk);
      xfer_viol = 1'b1; xfer_addr = a; xfer_wr = w; xfer_id = id;
      @(negedge clk);
      xfer_viol = 1'b0;
   endtask

   task automatic cfg(input logic hit, input logic allow, input logic [ADDR_W-1:0] a,
                      input logic w, input logic [ID_W-1:0] id);
      @(negedge clk);
      cfg_acc = 1'b1; cfg_hit = hit; cfg_allow = allow; cfg_addr = a; cfg_wr = w; cfg_id = id;
      @(negedge clk);
      cfg_acc = 1'b0;
   endtask

   function automatic logic [DATA_W-1:0] fstat(input logic w, input logic kind, input logic [ID_W-1:0] id);
      return DATA_W'(1) | (DATA_W'(w) << 1) | (DATA_W'(kind) << 2) | (DATA_W'(id) << 3);
   endfunction

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #200000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state and unmapped indices
      for (int i = 0; i < 8; i++) check_rd("R12 reset read", i, '0);
      check("R12 irq_addr reset", DATA_W'(irq_addr_err), '0);
      check("R12 irq_prot reset", DATA_W'(irq_prot_err), '0);

      // R1 and R4: addressing fault from config space
      cfg(1'b0, 1'b1, 16'h0abc, 1'b1, 3'd5);
      check_rd("R1 raw after miss", 1, 32'h1);
      check_rd("R4 faddr cfg", 3, 32'h0abc);
      check_rd("R4 fstat cfg", 4, fstat(1'b1, 1'b1, 3'd5));
      check("R7 irq masked", DATA_W'(irq_addr_err), '0);
      wr(0, 32'h3);
      check("R7 irq after enable", DATA_W'(irq_addr_err), 32'h1);
      check_rd("R8 enstat", 2, 32'h1);
      // R9: zero bits leave bit 0; one clears it
      wr(2, 32'h2);
      check_rd("R9 zero no effect", 1, 32'h1);
      wr(2, 32'h1);
      check_rd("R9 w1c", 1, 32'h0);
      check("R9 irq dropped", DATA_W'(irq_addr_err), '0);

      // R2 and R5: second fault while held
      xfer(16'h1234, 1'b0, 3'd2);
      check_rd("R2 raw prot", 1, 32'h2);
      check("R2 irq prot", DATA_W'(irq_prot_err), 32'h1);
      check_rd("R5 faddr held", 3, 32'h0abc);
      check_rd("R5 fstat held", 4, fstat(1'b1, 1'b1, 3'd5));
      // R6 clear
      wr(5, 32'h0);
      check_rd("R6 faddr cleared", 3, '0);
      check_rd("R6 fstat cleared", 4, '0);
      check_rd("R6 raw kept", 1, 32'h2);
      wr(2, 32'h3);

      // R4 sweep over direction and initiator
      for (int w = 0; w < 2; w++) begin
         for (int id = 0; id < 8; id++) begin
            logic [ADDR_W-1:0] a;
            a = ADDR_W'(16'h1000 + id * 37 + w * 977);
            xfer(a, w[0], id[ID_W-1:0]);
            check_rd("R4 sweep faddr", 3, DATA_W'(a));
            check_rd("R4 sweep fstat", 4, fstat(w[0], 1'b0, id[ID_W-1:0]));
            wr(5, 32'h0);
         end
      end
      wr(2, 32'h3);

      // R3: refused config access and permitted one
      cfg(1'b1, 1'b1, 16'h0040, 1'b1, 3'd1);
      check_rd("R3 allowed no raw", 1, '0);
      check_rd("R3 allowed no capture", 4, '0);
      cfg(1'b1, 1'b0, 16'h0044, 1'b1, 3'd6);
      check_rd("R3 refused raw", 1, 32'h2);
      check_rd("R3 refused fstat", 4, fstat(1'b1, 1'b0, 3'd6));
      wr(5, 32'h0);
      wr(2, 32'h3);

      // R7 R8 R10 sweep of enable and pending
      for (int en = 0; en < 4; en++) begin
         for (int rv = 0; rv < 4; rv++) begin
            wr(2, 32'h3);
            wr(0, DATA_W'(en));
            wr(1, DATA_W'(rv));
            check_rd("R10 raw set", 1, DATA_W'(rv));
            check_rd("R8 enstat", 2, DATA_W'(rv & en));
            check("R7 irq_addr", DATA_W'(irq_addr_err), DATA_W'((rv & en) & 1));
            check("R7 irq_prot", DATA_W'(irq_prot_err), DATA_W'(((rv & en) >> 1) & 1));
         end
      end
      wr(2, 32'h3);

      // R11: event beats same-cycle clear; transfer wins capture
      @(negedge clk);
      xfer_viol = 1'b1; xfer_addr = 16'h7777; xfer_wr = 1'b1; xfer_id = 3'd3;
      cfg_acc = 1'b1; cfg_hit = 1'b0; cfg_allow = 1'b0; cfg_addr = 16'h0111; cfg_wr = 1'b0; cfg_id = 3'd4;
      reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h3;
      @(negedge clk);
      xfer_viol = 1'b0; cfg_acc = 1'b0; reg_we = 1'b0; reg_wdata = '0;
      check_rd("R11 set beats clear", 1, 32'h3);
      check_rd("R11 xfer captured addr", 3, 32'h7777);
      check_rd("R11 xfer captured fstat", 4, fstat(1'b1, 1'b0, 3'd3));

      finish_run();
   end
endmodule